// File: doc/BRIEF.md
# Fault Recovery Hold Timer

This block controls the active-low tristate enable of an output power stage after a fault. When the fault input goes high, the tristate output falls at once, through a purely combinational path, so it does not wait for any clock edge. After the fault clears, the output stays low for a recovery interval. That interval is a 16-bit constant multiplied by a fixed tick period of about 0.083 ms, which is a 12 kHz tick.

The recovery constant sits in two byte-wide registers on a small address/data bus, and both registers can be read back. A prescaler divides the system clock down to the tick. The system clock and the tick rate are parameters, and the division ratio is derived from them. A hold counter then measures out the recovery interval.

The counting logic sees the fault input only after a two-flop synchroniser. A fault that comes back during recovery restarts the full interval.

Top module: `fault_hold_timer`

## Requirements
- R1: While `fault_i` is 1, `tristate_no` is 0 in the same instant, without waiting for a clock edge.
- R2: After `fault_i` falls, and with no further fault, `tristate_no` returns to 1 on the rising clock edge numbered K*DIV+2 after the fall. Here K is the effective constant, DIV = CLK_HZ/TICK_HZ, and the extra 2 edges come from the synchroniser.
- R3: After reset, the stored constant is 0x300C. It reads back as 0x30 at the high byte and 0x0C at the low byte, and a hold taken with no prior write lasts 0x300C ticks.
- R4: A stored value of 0x0000 is reserved. It gives a hold of exactly one tick, and it still reads back as 0x00 in both bytes.
- R5: A write (`bus_req_i`=1, `bus_we_i`=1) to address 0x3C sets bits 15:8 of the constant, and a write to 0x3D sets bits 7:0. A read (`bus_req_i`=1, `bus_we_i`=0) returns the stored byte on `bus_rdata_o` one clock later.
- R6: A write to any address other than 0x3C or 0x3D changes nothing. A read of any other address returns 0x00.
- R7: If the fault comes back while the recovery interval is running, the interval restarts in full. The release then follows R2, counted from the last fall of `fault_i`.
- R8: The hold counter takes the constant as it stands while the synchronised fault is high. A write made during the countdown does not change the hold already running, and it takes effect from the next hold.
- R9: `rst_ni` is an active-low synchronous reset. The first clock edge with `rst_ni`=0 ends any hold, so `tristate_no` returns to 1 unless `fault_i` is high, and it clears the prescaler and the counter.
- R10: The prescaler is held clear except while the hold is counting down. The first tick comes DIV cycles after the countdown starts, and each later tick comes DIV cycles after the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| fault_i | input | 1 | Fault indication, active high, asynchronous |
| tristate_no | output | 1 | Power stage tristate control, active low |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid one cycle after a read request |

## Verification
Some behaviours are checked on every cycle, whatever the stimulus:
- `tristate_no` is forced low whenever the fault input is high.
- A synchronised fault always arms the hold.
- The count stays still between ticks and drops by exactly one on each tick.
- Ticks occur only during the countdown.
- An armed hold never carries a zero count.
- An unmapped read returns zero.
- Reset drops the hold.

Only the bench scenarios can show the whole release time, measured in edges from the fault's fall, for a range of constants. The same goes for three other behaviours:
- the reserved zero value and the 0x300C default;
- restarting the hold when the fault comes back;
- a write made mid-hold taking effect only from the following hold.

// File: rtl/fht_pkg.sv
package fht_pkg;

    localparam logic [7:0]  ADDR_K_HI   = 8'h3C;
    localparam logic [7:0]  ADDR_K_LO   = 8'h3D;
    localparam logic [15:0] K_RESET_VAL = 16'h300C;

    typedef struct packed {
        logic [7:0] k_hi;
        logic [7:0] k_lo;
        logic [7:0] rdata;
    } regs_state_t;

    typedef struct packed {
        logic        active;
        logic [15:0] cnt;
    } hold_state_t;

    typedef struct packed {
        logic meta;
        logic sync;
    } sync_state_t;

endpackage

// File: rtl/fht_sync.sv
module fht_sync
    import fht_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.sync = st_q.meta;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.sync;

endmodule

// File: rtl/fht_prescaler.sv
module fht_prescaler #(
    parameter int unsigned DIV = 16666
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);

    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       wrap;

    assign wrap = run_i && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = wrap;

endmodule

// File: rtl/fht_regs.sv
module fht_regs
    import fht_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        req_i,
    input  logic        we_i,
    input  logic [7:0]  addr_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    output logic [15:0] k_eff_o
);

    regs_state_t st_d, st_q;
    logic        hit_hi, hit_lo;
    logic [15:0] k_raw;

    assign hit_hi = (addr_i == ADDR_K_HI);
    assign hit_lo = (addr_i == ADDR_K_LO);

    always_comb begin
        st_d       = st_q;
        st_d.rdata = 8'h00;
        if (req_i && we_i) begin
            if (hit_hi) st_d.k_hi = wdata_i;
            if (hit_lo) st_d.k_lo = wdata_i;
        end
        if (req_i && !we_i) begin
            if (hit_hi)      st_d.rdata = st_q.k_hi;
            else if (hit_lo) st_d.rdata = st_q.k_lo;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.k_hi  <= K_RESET_VAL[15:8];
            st_q.k_lo  <= K_RESET_VAL[7:0];
            st_q.rdata <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    assign k_raw   = {st_q.k_hi, st_q.k_lo};
    assign k_eff_o = (k_raw == 16'h0000) ? 16'h0001 : k_raw;
    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/fht_hold.sv
module fht_hold
    import fht_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        fault_sync_i,
    input  logic        tick_i,
    input  logic [15:0] k_i,
    output logic        active_o,
    output logic        count_run_o,
    output logic [15:0] cnt_o
);

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fault_sync_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = k_i;
        end else if (st_q.active && tick_i) begin
            if (st_q.cnt == 16'd1) begin
                st_d.active = 1'b0;
                st_d.cnt    = 16'd0;
            end else begin
                st_d.cnt = st_q.cnt - 16'd1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o    = st_q.active;
    assign count_run_o = st_q.active && !fault_sync_i;
    assign cnt_o       = st_q.cnt;

endmodule

// File: rtl/fault_hold_timer.sv
module fault_hold_timer #(
    parameter int unsigned CLK_HZ  = 200_000_000,
    parameter int unsigned TICK_HZ = 12_000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       fault_i,
    output logic       tristate_no,
    input  logic       bus_req_i,
    input  logic       bus_we_i,
    input  logic [7:0] bus_addr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o
);

    localparam int unsigned DIV = CLK_HZ / TICK_HZ;

    logic        fault_sync;
    logic        tick;
    logic        count_run;
    logic        hold_active;
    logic [15:0] hold_cnt;
    logic [15:0] k_eff;

    fht_sync u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (fault_i),
        .sync_o  (fault_sync)
    );

    fht_regs u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (bus_req_i),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .k_eff_o (k_eff)
    );

    fht_prescaler #(.DIV(DIV)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (count_run),
        .tick_o (tick)
    );

    fht_hold u_hold (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .fault_sync_i (fault_sync),
        .tick_i       (tick),
        .k_i          (k_eff),
        .active_o     (hold_active),
        .count_run_o  (count_run),
        .cnt_o        (hold_cnt)
    );

    // Asynchronous path: the fault pulls the enable low without a clock.
    assign tristate_no = ~(fault_i | hold_active);

endmodule

// File: rtl/fht_checker.sv
module fht_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        fault_i,
    input logic        tristate_no,
    input logic        fault_sync,
    input logic        tick,
    input logic        hold_active,
    input logic [15:0] hold_cnt,
    input logic        bus_req_i,
    input logic        bus_we_i,
    input logic [7:0]  bus_addr_i,
    input logic [7:0]  bus_rdata_o
);

    p_fault_forces_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_i |-> !tristate_no);

    p_sync_arms_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_sync |=> hold_active);

    p_no_release_between_ticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_active && !fault_sync && !tick) |=> hold_active);

    p_count_still_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_active && !fault_sync && !tick) |=> $stable(hold_cnt));

    p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_active && !fault_sync && tick && (hold_cnt > 16'd1))
        |=> (hold_cnt == $past(hold_cnt) - 16'd1));

    p_armed_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_active |-> (hold_cnt != 16'd0));

    p_tick_only_counting_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick |-> (hold_active && !fault_sync));

    p_unmapped_read_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_i && !bus_we_i && (bus_addr_i != 8'h3C) && (bus_addr_i != 8'h3D))
        |=> (bus_rdata_o == 8'h00));

    p_reset_drops_hold_r9: assert property (@(posedge clk_i)
        !rst_ni |=> !hold_active);

endmodule

bind fault_hold_timer fht_checker u_fht_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fault_i     (fault_i),
    .tristate_no (tristate_no),
    .fault_sync  (fault_sync),
    .tick        (tick),
    .hold_active (hold_active),
    .hold_cnt    (hold_cnt),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o)
);

// File: tb/fault_hold_timer_bench.sv
module fault_hold_timer_bench;

    localparam int unsigned CLK_HZ  = 48_000;
    localparam int unsigned TICK_HZ = 12_000;
    localparam int unsigned DIV     = CLK_HZ / TICK_HZ;

    typedef struct packed {
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic [31:0] ticks;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 8'h01, 32'd1},
        '{8'h00, 8'h03, 32'd3},
        '{8'h00, 8'h00, 32'd1},
        '{8'h01, 8'h02, 32'd258},
        '{8'h00, 8'h11, 32'd17}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fault = 1'b0;
    logic       tri_n;
    logic       req = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fault_hold_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_fault_hold_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .fault_i     (fault),
        .tristate_no (tri_n),
        .bus_req_i   (req),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        req = 1'b0;
    endtask

    task automatic raise_fault(input string tag);
        fault = 1'b1;
        #1;
        check(tri_n == 1'b0, tag, int'(tri_n), 0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Counts posedges from now until tristate is seen high.
    task automatic measure(output int n);
        n = 0;
        while (n < 150000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (tri_n) break;
        end
    endtask

    task automatic one_hold(output int n);
        raise_fault("R1 fault forces low");
        fault = 1'b0;
        measure(n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rb;
        int n;
        int n2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        check(tri_n == 1'b1, "R3 output high after reset", int'(tri_n), 1);
        bus_read(8'h3C, rb);
        check(rb == 8'h30, "R3 default high byte", int'(rb), 'h30);
        bus_read(8'h3D, rb);
        check(rb == 8'h0C, "R3 default low byte", int'(rb), 'h0C);
        one_hold(n);
        check(n == 16'h300C * DIV + 2, "R3 default hold length", n, 16'h300C * DIV + 2);

        // R2 R4 R5: table of constants
        for (int i = 0; i < NVEC; i++) begin
            bus_write(8'h3C, VECS[i].hi);
            bus_write(8'h3D, VECS[i].lo);
            bus_read(8'h3C, rb);
            check(rb == VECS[i].hi, "R5 high byte readback", int'(rb), int'(VECS[i].hi));
            bus_read(8'h3D, rb);
            check(rb == VECS[i].lo, "R5 low byte readback", int'(rb), int'(VECS[i].lo));
            one_hold(n);
            check(n == int'(VECS[i].ticks) * DIV + 2, "R2 R4 hold length", n,
                  int'(VECS[i].ticks) * DIV + 2);
        end

        // R6: unmapped addresses ignored
        bus_write(8'h3C, 8'h00);
        bus_write(8'h3D, 8'h06);
        bus_write(8'h3E, 8'hFF);
        bus_write(8'h3B, 8'hAA);
        bus_write(8'h00, 8'h55);
        bus_read(8'h3C, rb);
        check(rb == 8'h00, "R6 high byte untouched", int'(rb), 0);
        bus_read(8'h3D, rb);
        check(rb == 8'h06, "R6 low byte untouched", int'(rb), 6);
        bus_read(8'h3E, rb);
        check(rb == 8'h00, "R6 unmapped read zero", int'(rb), 0);
        bus_read(8'h3B, rb);
        check(rb == 8'h00, "R6 unmapped read zero", int'(rb), 0);
        one_hold(n);
        check(n == 6 * DIV + 2, "R6 hold unchanged", n, 6 * DIV + 2);

        // R7: reassert during hold restarts it
        bus_write(8'h3D, 8'h0A);
        raise_fault("R1 fault forces low");
        fault = 1'b0;
        repeat (20) @(negedge clk);
        check(tri_n == 1'b0, "R7 still holding", int'(tri_n), 0);
        raise_fault("R1 refault forces low");
        fault = 1'b0;
        measure(n);
        check(n == 10 * DIV + 2, "R7 full restart", n, 10 * DIV + 2);

        // R8: write during countdown affects next hold only
        bus_write(8'h3D, 8'h05);
        raise_fault("R1 fault forces low");
        fault = 1'b0;
        repeat (3) @(negedge clk);
        bus_write(8'h3C, 8'h00);
        bus_write(8'h3D, 8'h14);
        measure(n);
        check(n + 5 == 5 * DIV + 2, "R8 running hold keeps old constant", n + 5, 5 * DIV + 2);
        one_hold(n2);
        check(n2 == 20 * DIV + 2, "R8 next hold uses new constant", n2, 20 * DIV + 2);

        // R10: low-byte 1 gives exactly one prescaler period
        bus_write(8'h3D, 8'h01);
        one_hold(n);
        check(n == DIV + 2, "R10 single tick period", n, DIV + 2);

        // R9: reset mid-hold releases and restores default
        bus_write(8'h3D, 8'h40);
        raise_fault("R1 fault forces low");
        fault = 1'b0;
        repeat (10) @(negedge clk);
        check(tri_n == 1'b0, "R9 holding before reset", int'(tri_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(tri_n == 1'b1, "R9 reset releases output", int'(tri_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(8'h3D, rb);
        check(rb == 8'h0C, "R9 reset restores low byte", int'(rb), 'h0C);
        bus_write(8'h3C, 8'h00);
        bus_write(8'h3D, 8'h02);
        one_hold(n);
        check(n == 2 * DIV + 2, "R9 R10 clean count after reset", n, 2 * DIV + 2);

        finish_run();
    end

endmodule